// File: doc/BRIEF.md
# Maskable Interrupt Controller with Idle Wake-Up

This block gathers up to 32 interrupt request lines from peripherals and turns them into two processor interrupt signals. One is a normal interrupt and the other is a fast interrupt. Each request line is registered into a pending bit that tracks the line. A peripheral clears its bit by dropping its request. Software can read the pending bits at any time. An enable (mask) register decides which pending bits may become active. A routing register sends each active bit to either the normal or the fast output.

While the system is in its low-power idle state, the enable register is bypassed. Any pending request then becomes active and drives the routed interrupt outputs. It also raises a wake-up output for the power controller, which falls again once idle is left. Software reaches the registers through a small word-addressed bus. Writes take effect on the clock edge, and reads are combinational.

Top module: `irq_mask_ctrl`

## Requirements
- R1: A pending bit equals the value its request line had at the previous rising clock edge. The raw pending bits read at word offset 4.
- R2: The enable register (offset 1) and the routing register (offset 2) are written when `bus_wr` is high at a rising edge, and they read back the written value.
- R3: With idle low, a pending bit whose enable bit is 0 drives neither `irq_o` nor `fiq_o`, and it stays visible at offset 4.
- R4: With idle low, a pending bit with enable 1 and routing 0 raises `irq_o` one clock after the pending bit is set, and `fiq_o` stays low for it.
- R5: With idle low, a pending bit with enable 1 and routing 1 raises `fiq_o` one clock after the pending bit is set, and `irq_o` stays low for it.
- R6: Offset 0 reads the active bits routed to the normal output, and offset 3 reads the active bits routed to the fast output. The two never share a set bit.
- R7: While `idle_i` is high, every pending bit is active whatever its enable bit, and it is routed by its routing bit.
- R8: `wake_o` is the registered OR of all pending bits while `idle_i` is high. It is low in the clock after `idle_i` was sampled low.
- R9: After reset, the pending bits, the routing register, `irq_o`, `fiq_o` and `wake_o` are all zero. The enable register has no defined reset value.
- R10: Dropping a request line clears its pending bit on the next edge. The interrupt outputs fall one clock later.
- R11: Bus writes to offsets 0, 3, 4 and 5 to 7 change no register, and offsets 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 32 | Level request line per source |
| idle_i | input | 1 | High while the system is idle; bypasses the enable register |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Registered normal interrupt |
| fiq_o | output | 1 | Registered fast interrupt |
| wake_o | output | 1 | Registered wake-up request to the power controller |

## Verification
The hardest case to reach is the idle bypass combined with a fully cleared enable register and a source routed to the fast output. The output must then come only from the bypass. Every individual source is walked through the sequence masked, enabled, rerouted, idle with enable cleared, and released. This drives each bit position through every path separately. A long pseudo-random run then mixes request, enable, routing and idle values. Each result is compared against a bit-by-bit model in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    REG_IRQ_ACT = 3'd0,
    REG_ENABLE  = 3'd1,
    REG_ROUTE   = 3'd2,
    REG_FIQ_ACT = 3'd3,
    REG_RAW     = 3'd4
  } irqc_reg_e;
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  output logic [N_SRC-1:0] pend_q
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      past_ok <= 1'b0;
    end else begin
      pend_q  <= src_req;
      past_ok <= 1'b1;
    end
  end

  AST_PEND_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> pend_q == $past(src_req)); // R1

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(src_req) == '0) |-> pend_q == '0); // R10
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  enable_q,
  output logic [N_SRC-1:0]  route_q
);
  import irqc_pkg::*;

  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(REG_ENABLE);
  localparam logic [ADDR_W-1:0] A_ROUTE  = ADDR_W'(REG_ROUTE);

  logic wr_enable;
  logic wr_route;
  logic past_ok;

  assign wr_enable = bus_wr && (bus_addr == A_ENABLE);
  assign wr_route  = bus_wr && (bus_addr == A_ROUTE);

  // enable register deliberately carries no reset value
  always_ff @(posedge clk) begin
    if (wr_enable) enable_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (wr_route) route_q <= bus_wdata;
    end
  end

  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> enable_q == $past(bus_wdata)); // R2

  AST_ROUTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_route |=> route_q == $past(bus_wdata)); // R2

  AST_OTHER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && bus_wr && bus_addr != A_ENABLE && bus_addr != A_ROUTE)
      |=> ($stable(enable_q) && $stable(route_q))); // R11
endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] enable,
  input  logic [N_SRC-1:0] route,
  input  logic             idle_i,
  output logic [N_SRC-1:0] act_irq,
  output logic [N_SRC-1:0] act_fiq,
  output logic             irq_o,
  output logic             fiq_o,
  output logic             wake_o
);
  function automatic logic [N_SRC-1:0] gate(input logic [N_SRC-1:0] p,
                                            input logic [N_SRC-1:0] en,
                                            input logic             bypass);
    return bypass ? p : (p & en);
  endfunction

  function automatic logic [N_SRC-1:0] pick(input logic [N_SRC-1:0] a,
                                            input logic [N_SRC-1:0] r,
                                            input logic             fast);
    return fast ? (a & r) : (a & ~r);
  endfunction

  logic [N_SRC-1:0] active;
  logic             past_ok;

  assign active  = gate(pend, enable, idle_i);
  assign act_irq = pick(active, route, 1'b0);
  assign act_fiq = pick(active, route, 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
      wake_o  <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      irq_o   <= |act_irq;
      fiq_o   <= |act_fiq;
      wake_o  <= idle_i && (|pend);
      past_ok <= 1'b1;
    end
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(idle_i) && ($past(pend & enable) == '0)) |-> (!irq_o && !fiq_o)); // R3

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(idle_i) && ($past(pend & enable & ~route) != '0)) |-> irq_o); // R4

  AST_FIQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(idle_i) && ($past(pend & enable & route) != '0)) |-> fiq_o); // R5

  AST_SPLIT_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_irq & act_fiq) == '0); // R6

  AST_IDLE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && (pend != '0)) |=> (irq_o || fiq_o)); // R7

  AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && (pend != '0)) |=> wake_o); // R8

  AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> !wake_o); // R8
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              idle_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              wake_o
);
  import irqc_pkg::*;

  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] enable_q;
  logic [N_SRC-1:0] route_q;
  logic [N_SRC-1:0] act_irq;
  logic [N_SRC-1:0] act_fiq;

  irqc_pending #(.N_SRC(N_SRC)) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_req(src_req),
    .pend_q (pend_q)
  );

  irqc_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .enable_q (enable_q),
    .route_q  (route_q)
  );

  irqc_route #(.N_SRC(N_SRC)) u_route (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend   (pend_q),
    .enable (enable_q),
    .route  (route_q),
    .idle_i (idle_i),
    .act_irq(act_irq),
    .act_fiq(act_fiq),
    .irq_o  (irq_o),
    .fiq_o  (fiq_o),
    .wake_o (wake_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(REG_IRQ_ACT))      bus_rdata = act_irq;
    else if (bus_addr == ADDR_W'(REG_ENABLE))  bus_rdata = enable_q;
    else if (bus_addr == ADDR_W'(REG_ROUTE))   bus_rdata = route_q;
    else if (bus_addr == ADDR_W'(REG_FIQ_ACT)) bus_rdata = act_fiq;
    else if (bus_addr == ADDR_W'(REG_RAW))     bus_rdata = pend_q;
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(REG_RAW)) |-> bus_rdata == '0); // R11

  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_o && !fiq_o && !wake_o)); // R9
endmodule

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic        idle_i = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_mask_ctrl u_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .idle_i(idle_i),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // bench model: walk bit by bit
  task automatic model(input logic [31:0] p, input logic [31:0] en, input logic [31:0] rt,
                       input logic idl, output logic [31:0] ai, output logic [31:0] af);
    ai = '0; af = '0;
    for (int b = 0; b < 32; b++) begin
      if (p[b] && (idl || en[b])) begin
        if (rt[b]) af[b] = 1'b1; else ai[b] = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ei, ef, lfsr, rs, rm, rl;
    logic ri;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    rd(3'd4, d); chk("R9 raw pending", d, 0);
    rd(3'd2, d); chk("R9 routing", d, 0);
    chk("R9 irq", {31'd0, irq_o}, 0);
    chk("R9 fiq", {31'd0, fiq_o}, 0);
    chk("R9 wake", {31'd0, wake_o}, 0);

    // R2 read-back
    wr(3'd1, 32'hA5C3_0F96); rd(3'd1, d); chk("R2 enable", d, 32'hA5C3_0F96);
    wr(3'd2, 32'h5A3C_F069); rd(3'd2, d); chk("R2 routing", d, 32'h5A3C_F069);

    // R11 writes to read-only / unused offsets
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd3, 32'h1234_5678);
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd6, 32'hDEAD_BEEF);
    rd(3'd1, d); chk("R11 enable kept", d, 32'hA5C3_0F96);
    rd(3'd2, d); chk("R11 routing kept", d, 32'h5A3C_F069);
    rd(3'd4, d); chk("R11 raw kept", d, 0);
    for (int a = 5; a < 8; a++) begin
      rd(a[2:0], d); chk("R11 unused reads zero", d, 0);
    end

    // per-source walk
    for (int i = 0; i < 32; i++) begin
      wr(3'd1, 0); wr(3'd2, 0);
      src_req = 32'd1 << i;
      @(negedge clk); @(negedge clk);
      rd(3'd4, d); chk("R1 raw pending", d, 32'd1 << i);
      chk("R3 masked irq", {31'd0, irq_o}, 0);
      chk("R3 masked fiq", {31'd0, fiq_o}, 0);
      wr(3'd1, 32'd1 << i); @(negedge clk);
      chk("R4 irq", {31'd0, irq_o}, 1);
      chk("R4 fiq low", {31'd0, fiq_o}, 0);
      rd(3'd0, d); chk("R6 irq active", d, 32'd1 << i);
      wr(3'd2, 32'd1 << i); @(negedge clk);
      chk("R5 fiq", {31'd0, fiq_o}, 1);
      chk("R5 irq low", {31'd0, irq_o}, 0);
      rd(3'd3, d); chk("R6 fiq active", d, 32'd1 << i);
      rd(3'd0, d); chk("R6 irq empty", d, 0);
      wr(3'd1, 0);
      idle_i = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R7 idle bypass fiq", {31'd0, fiq_o}, 1);
      chk("R8 wake", {31'd0, wake_o}, 1);
      rd(3'd3, d); chk("R7 idle active", d, 32'd1 << i);
      idle_i = 1'b0;
      @(negedge clk);
      chk("R8 wake drops", {31'd0, wake_o}, 0);
      chk("R3 mask back", {31'd0, fiq_o}, 0);
      idle_i = 1'b1;
      src_req = '0;
      @(negedge clk);
      rd(3'd4, d); chk("R10 cleared", d, 0);
      @(negedge clk);
      chk("R10 fiq falls", {31'd0, fiq_o}, 0);
      chk("R10 wake falls", {31'd0, wake_o}, 0);
      idle_i = 1'b0;
    end

    // mixed patterns
    lfsr = 32'hACE1_1357;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; rs = lfsr & {lfsr[15:0], lfsr[31:16]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; rm = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; rl = lfsr;
      ri = (k % 4) == 3;
      if (k % 16 == 5) rm = 0;
      wr(3'd1, rm); wr(3'd2, rl);
      src_req = rs; idle_i = ri;
      @(negedge clk); @(negedge clk);
      model(rs, rm, rl, ri, ei, ef);
      rd(3'd4, d); chk("R1 mixed raw", d, rs);
      rd(3'd0, d); chk("R6 mixed irq set", d, ei);
      rd(3'd3, d); chk("R6 mixed fiq set", d, ef);
      chk("R4 mixed irq", {31'd0, irq_o}, {31'd0, |ei});
      chk("R5 mixed fiq", {31'd0, fiq_o}, {31'd0, |ef});
      chk("R8 mixed wake", {31'd0, wake_o}, {31'd0, ri && (rs != 0)});
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule